// File: doc/BRIEF.md
# Display Control Register Decoder

This block takes 32-bit display-control words, each carrying an opcode in its top byte, and keeps the display state those words describe. That state is a 31-bit status word, the display start position, the horizontal and vertical display ranges, and the resolution mode. From these it derives the visible picture width and height. A copy of the last accepted word for each banked opcode is kept. A new word that matches its stored copy is dropped, so rewriting the same value costs nothing and does not mark the display as changed.

The width is the horizontal span scaled by the horizontal resolution over a full-scale span of 2560. That needs a multiply and a divide, which a small restoring divider handles over several cycles while `geom_busy_o` is high. The height is a subtraction, an optional doubling and a fallback, so it updates in the cycle of the write. A vertical-blank strobe advances a field-parity bit, which is shown in bit 31 of the status output.

Top module: `dispctl_top`

## Requirements
- R1: After reset, `status_o` is 0x14802000, hres 320, vres 240, width 320, height 240, the start position is 0, `dirty_o` is 0 and `geom_busy_o` is 0.
- R2: A write is ignored entirely when its opcode is 1 to 8 and the word equals the stored copy for that opcode. Stored copies reset to 0, except that opcode 3 resets to the value 1. Opcode 0 is never ignored. Opcodes of 9 and above are not stored and only set the dirty flag.
- R3: Every write that is not ignored sets `dirty_o`. A `dirty_clr` pulse clears it, unless a write is accepted in the same cycle.
- R4: Opcode 0 reloads status with 0x14802000, which has the blanking bit 23 set, and clears the field parity.
- R5: Opcode 3 copies data bit 0 into status bit 23. Opcode 4 copies data[1:0] into status bits 30:29.
- R6: Opcode 5 sets start X from data[9:0] and start Y from data[19:10].
- R7: Opcode 8 writes data[5:0] into status bits 22:17 and data bit 6 into status bit 16. It then sets hres from status[18:16] through the table {256,368,320,384,512,512,640,640} and vres from status[20:19] through the table {240,480,256,480}.
- R8: Opcode 6 loads X1 from data[11:0] and X2 from data[23:12]. With span = X2 − X1 (signed), the width is hres if span ≤ 0 or span ≥ 2560, and otherwise floor(span × hres / 2560). Opcode 8 recomputes the width with the new hres.
- R9: Opcode 7 loads Y1 from data[9:0] and Y2 from data[19:10]. The height is Y2 − Y1, doubled when status bit 19 is set, and falls back to vres if the result is ≤ 0. Opcode 8 recomputes it with the new bit 19 and vres.
- R10: Status bit 22 enables interlace. On a vertical-blank strobe with interlace on, the parity toggles when `vblank_val` is 1 and holds when it is 0. With interlace off, the parity is cleared. `status_o[31]` shows the parity.
- R11: While a width division is pending, `geom_busy_o` is high and `width_o` keeps its old value. A new width-affecting write restarts the computation, and the final width reflects the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word, opcode in bits 31:24 |
| dirty_clr | input | 1 | Clears the dirty flag |
| vblank_stb | input | 1 | Vertical-blank event strobe |
| vblank_val | input | 1 | Blank level carried with the strobe |
| status_o | output | 32 | Parity in bit 31, status register below |
| start_x_o | output | 10 | Display start X |
| start_y_o | output | 10 | Display start Y |
| hres_o | output | 10 | Horizontal resolution |
| vres_o | output | 9 | Vertical resolution |
| width_o | output | 10 | Effective visible width |
| height_o | output | 11 | Effective visible height |
| geom_busy_o | output | 1 | Width computation pending |
| dirty_o | output | 1 | Display state changed since last clear |

## Verification
The mode word is swept through all 128 values, which separates every hres and vres table entry and every status bit position. Under each of the eight horizontal modes, the width is driven with negative, zero, one, mid-range, 2559, 2560 and beyond-range spans, so the fallback edges on both sides and the truncating divide are told apart. Height spans are run with doubling both off and on, including spans that are negative or zero. Repeat writes, opcode 0 repeats, unbanked opcodes, vertical-blank sequences with interlace on and off, and back-to-back range writes then show the difference between ignored, accepted and restarted operations.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

   localparam int unsigned OPC_INIT   = 0;
   localparam int unsigned OPC_BLANK  = 3;
   localparam int unsigned OPC_DMA    = 4;
   localparam int unsigned OPC_START  = 5;
   localparam int unsigned OPC_HRANGE = 6;
   localparam int unsigned OPC_VRANGE = 7;
   localparam int unsigned OPC_MODE   = 8;

   localparam int unsigned BANK_MIN = 9;

   // field widths fixed by the control word layout
   localparam int unsigned OPW  = 8;
   localparam int unsigned POSW = 10;
   localparam int unsigned XW   = 12;
   localparam int unsigned YW   = 10;
   localparam int unsigned HW   = 10;
   localparam int unsigned VW   = 9;
   localparam int unsigned HTW  = YW + 1;

   localparam logic [30:0] STATUS_INIT = 31'h14802000;
   localparam int unsigned BIT_BLANK   = 23;
   localparam int unsigned BIT_ILACE   = 22;
   localparam int unsigned BIT_DHEIGHT = 19;

   localparam logic [HW-1:0] HRES_RST = 10'd320;
   localparam logic [VW-1:0] VRES_RST = 9'd240;

   function automatic logic [HW-1:0] hres_of(input logic [2:0] idx);
      case (idx)
         3'd0:    return 10'd256;
         3'd1:    return 10'd368;
         3'd2:    return 10'd320;
         3'd3:    return 10'd384;
         3'd4,
         3'd5:    return 10'd512;
         default: return 10'd640;
      endcase
   endfunction

   function automatic logic [VW-1:0] vres_of(input logic [1:0] idx);
      case (idx)
         2'd0:    return 9'd240;
         2'd2:    return 9'd256;
         default: return 9'd480;
      endcase
   endfunction

endpackage

// File: rtl/dispctl_div.sv
module dispctl_div #(
   parameter int unsigned NW = 22,
   parameter int unsigned DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          kill,
   input  logic [NW-1:0] num,
   input  logic [DW-1:0] den,
   output logic          busy,
   output logic          done,
   output logic [NW-1:0] quot
);
   localparam int unsigned CW = $clog2(NW + 1);

   logic [DW-1:0] rem_q;
   logic [NW-1:0] q_q;
   logic [CW-1:0] cnt_q;
   logic [DW:0]   trial;
   logic          ge;

   assign trial = {rem_q, q_q[NW-1]};
   assign ge    = trial >= {1'b0, den};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         q_q   <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem_q <= '0;
            q_q   <= num;
            cnt_q <= CW'(NW);
            busy  <= 1'b1;
         end else if (kill) begin
            busy <= 1'b0;
         end else if (busy) begin
            rem_q <= ge ? DW'(trial - {1'b0, den}) : trial[DW-1:0];
            q_q   <= {q_q[NW-2:0], ge};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign quot = q_q;

   // R11: partial remainder stays below the divisor through the run
   assert_rem_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rem_q < den));

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
   import dispctl_pkg::*;
#(
   parameter int unsigned NREG = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [31:0]     wr_data,
   input  logic            dirty_clr,
   input  logic            vblank_stb,
   input  logic            vblank_val,
   output logic            acc_o,
   output logic            dheight_o,
   output logic [31:0]     status_o,
   output logic [POSW-1:0] start_x_o,
   output logic [POSW-1:0] start_y_o,
   output logic            dirty_o
);
   logic [OPW-1:0]             op;
   logic [NREG-1:0][31:0]      shadow;
   logic                       rep_hit;
   logic                       acc;
   logic [30:0]                stat_q;
   logic                       par_q;
   logic                       dirty_q;
   logic [POSW-1:0]            sx_q, sy_q;

   assign op = wr_data[31:24];

   always_comb begin
      rep_hit = 1'b0;
      for (int i = 1; i < int'(NREG); i++) begin
         if (op == OPW'(i) && shadow[i] == wr_data) rep_hit = 1'b1;
      end
   end

   assign acc = wr_en && !rep_hit;

   for (genvar g = 0; g < int'(NREG); g++) begin : g_shadow
      localparam logic [31:0] RSTV = (g == int'(OPC_BLANK)) ? 32'd1 : 32'd0;
      logic [31:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                     q <= RSTV;
         else if (acc && op == OPW'(g))  q <= wr_data;
      end
      assign shadow[g] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q  <= STATUS_INIT;
         par_q   <= 1'b0;
         dirty_q <= 1'b0;
         sx_q    <= '0;
         sy_q    <= '0;
      end else begin
         if (acc)            dirty_q <= 1'b1;
         else if (dirty_clr) dirty_q <= 1'b0;

         if (vblank_stb) begin
            if (stat_q[BIT_ILACE]) par_q <= par_q ^ vblank_val;
            else                   par_q <= 1'b0;
         end

         if (acc) begin
            case (int'(op))
               OPC_INIT: begin
                  stat_q <= STATUS_INIT;
                  par_q  <= 1'b0;
               end
               OPC_BLANK: stat_q[BIT_BLANK] <= wr_data[0];
               OPC_DMA:   stat_q[30:29]     <= wr_data[1:0];
               OPC_START: begin
                  sx_q <= wr_data[9:0];
                  sy_q <= wr_data[19:10];
               end
               OPC_MODE:  stat_q[22:16] <= {wr_data[5:0], wr_data[6]};
               default: ;
            endcase
         end
      end
   end

   assign acc_o     = acc;
   assign dheight_o = stat_q[BIT_DHEIGHT];
   assign status_o  = {par_q, stat_q};
   assign start_x_o = sx_q;
   assign start_y_o = sy_q;
   assign dirty_o   = dirty_q;

   assert_repeat_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rep_hit && !vblank_stb) |=> $stable(status_o));

   assert_repeat_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rep_hit && !dirty_clr) |=> $stable(dirty_o));

   assert_dirty_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> dirty_o);

   assert_init_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == '0) |=> (status_o == {1'b0, STATUS_INIT}));

   assert_parity_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank_stb && !status_o[BIT_ILACE]) |=> !status_o[31]);

endmodule

// File: rtl/dispctl_geom.sv
module dispctl_geom
   import dispctl_pkg::*;
#(
   parameter int unsigned SPAN_FULL = 2560,
   parameter bit          SEQ_DIV   = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           acc_i,
   input  logic [31:0]    wr_data,
   input  logic           dheight_i,
   output logic [HW-1:0]  hres_o,
   output logic [VW-1:0]  vres_o,
   output logic [HW-1:0]  width_o,
   output logic [HTW-1:0] height_o,
   output logic           busy_o
);
   localparam int unsigned PW = XW + HW;
   localparam int unsigned DW = $clog2(SPAN_FULL + 1);

   logic [OPW-1:0]        op;
   logic                  is_h, is_v, is_m, upd_w, upd_h;
   logic [XW-1:0]         x1_q, x2_q, nx1, nx2;
   logic [YW-1:0]         y1_q, y2_q, ny1, ny2;
   logic [HW-1:0]         hres_q, nhres, width_q;
   logic [VW-1:0]         vres_q, nvres;
   logic [HTW-1:0]        height_q, nheight;
   logic                  ndh, full;
   logic signed [XW:0]    span;
   logic signed [YW:0]    vspan;
   logic signed [YW+1:0]  vsz;
   logic [PW-1:0]         prod;

   assign op   = wr_data[31:24];
   assign is_h = op == OPW'(OPC_HRANGE);
   assign is_v = op == OPW'(OPC_VRANGE);
   assign is_m = op == OPW'(OPC_MODE);

   assign upd_w = acc_i && (is_h || is_m);
   assign upd_h = acc_i && (is_v || is_m);

   assign nx1   = is_h ? wr_data[11:0]  : x1_q;
   assign nx2   = is_h ? wr_data[23:12] : x2_q;
   assign ny1   = is_v ? wr_data[9:0]   : y1_q;
   assign ny2   = is_v ? wr_data[19:10] : y2_q;
   assign nhres = is_m ? hres_of({wr_data[1:0], wr_data[6]}) : hres_q;
   assign nvres = is_m ? vres_of(wr_data[3:2]) : vres_q;
   assign ndh   = is_m ? wr_data[2] : dheight_i;

   assign span = $signed({1'b0, nx2}) - $signed({1'b0, nx1});
   assign full = (span <= 0) || (span >= $signed((XW+1)'(SPAN_FULL)));
   assign prod = PW'(span[XW-1:0]) * PW'(nhres);

   assign vspan   = $signed({1'b0, ny2}) - $signed({1'b0, ny1});
   assign vsz     = ndh ? {vspan, 1'b0} : {vspan[YW], vspan};
   assign nheight = (vsz <= 0) ? HTW'(nvres) : vsz[YW:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x1_q     <= '0;
         x2_q     <= '0;
         y1_q     <= '0;
         y2_q     <= '0;
         hres_q   <= HRES_RST;
         vres_q   <= VRES_RST;
         height_q <= HTW'(VRES_RST);
      end else begin
         if (acc_i && is_h) begin
            x1_q <= nx1;
            x2_q <= nx2;
         end
         if (acc_i && is_v) begin
            y1_q <= ny1;
            y2_q <= ny2;
         end
         if (acc_i && is_m) begin
            hres_q <= nhres;
            vres_q <= nvres;
         end
         if (upd_h) height_q <= nheight;
      end
   end

   if (SEQ_DIV) begin : g_seq
      logic          dv_busy, dv_done;
      logic [PW-1:0] dv_quot;

      dispctl_div #(.NW(PW), .DW(DW)) u_div (
         .clk   (clk),
         .rst_n (rst_n),
         .start (upd_w && !full),
         .kill  (upd_w && full),
         .num   (prod),
         .den   (DW'(SPAN_FULL)),
         .busy  (dv_busy),
         .done  (dv_done),
         .quot  (dv_quot)
      );

      always_ff @(posedge clk) begin
         if (!rst_n)              width_q <= HRES_RST;
         else if (upd_w && full)  width_q <= nhres;
         else if (dv_done)        width_q <= dv_quot[HW-1:0];
      end

      assign busy_o = dv_busy || dv_done;

      // R11: width held while a division runs undisturbed
      assert_width_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (dv_busy && !upd_w) |=> $stable(width_q));
   end else begin : g_comb
      always_ff @(posedge clk) begin
         if (!rst_n)      width_q <= HRES_RST;
         else if (upd_w)  width_q <= full ? nhres : HW'(prod / PW'(SPAN_FULL));
      end
      assign busy_o = 1'b0;
   end

   assign hres_o   = hres_q;
   assign vres_o   = vres_q;
   assign width_o  = width_q;
   assign height_o = height_q;

   assert_width_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (width_q <= hres_q));

   assert_height_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
      height_q != '0);

endmodule

// File: rtl/dispctl_top.sv
module dispctl_top
   import dispctl_pkg::*;
#(
   parameter int unsigned NREG      = 9,
   parameter int unsigned SPAN_FULL = 2560,
   parameter bit          SEQ_DIV   = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [31:0]    wr_data,
   input  logic           dirty_clr,
   input  logic           vblank_stb,
   input  logic           vblank_val,
   output logic [31:0]    status_o,
   output logic [9:0]     start_x_o,
   output logic [9:0]     start_y_o,
   output logic [9:0]     hres_o,
   output logic [8:0]     vres_o,
   output logic [9:0]     width_o,
   output logic [10:0]    height_o,
   output logic           geom_busy_o,
   output logic           dirty_o
);
   if (NREG < BANK_MIN || NREG > 256) begin : g_bad_nreg
      $error("NREG must cover opcodes 0..8 and fit the opcode byte");
   end
   if (SPAN_FULL < 2 || SPAN_FULL >= (1 << XW)) begin : g_bad_span
      $error("SPAN_FULL must fit the horizontal range field");
   end

   logic acc, dheight;

   dispctl_regs #(.NREG(NREG)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .dirty_clr  (dirty_clr),
      .vblank_stb (vblank_stb),
      .vblank_val (vblank_val),
      .acc_o      (acc),
      .dheight_o  (dheight),
      .status_o   (status_o),
      .start_x_o  (start_x_o),
      .start_y_o  (start_y_o),
      .dirty_o    (dirty_o)
   );

   dispctl_geom #(.SPAN_FULL(SPAN_FULL), .SEQ_DIV(SEQ_DIV)) u_geom (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_i     (acc),
      .wr_data   (wr_data),
      .dheight_i (dheight),
      .hres_o    (hres_o),
      .vres_o    (vres_o),
      .width_o   (width_o),
      .height_o  (height_o),
      .busy_o    (geom_busy_o)
   );

endmodule

// File: tb/test_dispctl_top.sv
module test_dispctl_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        dirty_clr = 1'b0;
   logic        vblank_stb = 1'b0;
   logic        vblank_val = 1'b0;
   logic [31:0] status_o;
   logic [9:0]  start_x_o, start_y_o, hres_o, width_o;
   logic [8:0]  vres_o;
   logic [10:0] height_o;
   logic        geom_busy_o, dirty_o;

   int total = 0;
   int bad   = 0;

   // model state
   logic [31:0] m_sh [9];
   logic [30:0] m_stat;
   logic        m_par, m_dirty;
   int          m_sx, m_sy, m_x1, m_x2, m_y1, m_y2, m_hres, m_vres, m_w, m_h;

   dispctl_top i_dispctl_top (.*);

   always #10 clk = ~clk;   // 50 MHz

   initial begin
      #4000000;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic int hres_tab(int i);
      case (i)
         0: return 256; 1: return 368; 2: return 320; 3: return 384;
         4, 5: return 512; default: return 640;
      endcase
   endfunction

   function automatic int vres_tab(int i);
      case (i)
         0: return 240; 2: return 256; default: return 480;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic recompute_w();
      int s = m_x2 - m_x1;
      if (s <= 0 || s >= 2560) m_w = m_hres;
      else m_w = (s * m_hres) / 2560;
   endtask

   task automatic recompute_h();
      int s = m_y2 - m_y1;
      if (m_stat[19]) s = s * 2;
      m_h = (s <= 0) ? m_vres : s;
   endtask

   task automatic model(logic [31:0] d);
      int op = int'(d[31:24]);
      if (op != 0 && op < 9 && m_sh[op] == d) return;
      m_dirty = 1'b1;
      if (op < 9) m_sh[op] = d;
      case (op)
         0: begin m_stat = 31'h14802000; m_par = 1'b0; end
         3: m_stat[23] = d[0];
         4: m_stat[30:29] = d[1:0];
         5: begin m_sx = int'(d[9:0]); m_sy = int'(d[19:10]); end
         6: begin m_x1 = int'(d[11:0]); m_x2 = int'(d[23:12]); recompute_w(); end
         7: begin m_y1 = int'(d[9:0]); m_y2 = int'(d[19:10]); recompute_h(); end
         8: begin
            m_stat[22:16] = {d[5:0], d[6]};
            m_hres = hres_tab(int'(m_stat[18:16]));
            m_vres = vres_tab(int'(m_stat[20:19]));
            recompute_w();
            recompute_h();
         end
         default: ;
      endcase
   endtask

   task automatic wait_idle();
      while (geom_busy_o) @(negedge clk);
   endtask

   task automatic put(logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model(d);
      wait_idle();
   endtask

   task automatic clr();
      @(negedge clk);
      dirty_clr = 1'b1;
      @(negedge clk);
      dirty_clr = 1'b0;
      m_dirty = 1'b0;
   endtask

   task automatic vblank(logic v);
      @(negedge clk);
      vblank_stb = 1'b1;
      vblank_val = v;
      @(negedge clk);
      vblank_stb = 1'b0;
      if (m_stat[22]) m_par = m_par ^ v;
      else m_par = 1'b0;
   endtask

   task automatic cmp_all(string tag);
      chk({tag, " status"}, int'(status_o), int'({m_par, m_stat}));
      chk({tag, " sx"}, int'(start_x_o), m_sx);
      chk({tag, " sy"}, int'(start_y_o), m_sy);
      chk({tag, " hres"}, int'(hres_o), m_hres);
      chk({tag, " vres"}, int'(vres_o), m_vres);
      chk({tag, " width"}, int'(width_o), m_w);
      chk({tag, " height"}, int'(height_o), m_h);
      chk({tag, " dirty"}, int'(dirty_o), int'(m_dirty));
      chk({tag, " busy"}, int'(geom_busy_o), 0);
   endtask

   initial begin
      for (int i = 0; i < 9; i++) m_sh[i] = '0;
      m_sh[3] = 32'd1;
      m_stat = 31'h14802000; m_par = 1'b0; m_dirty = 1'b0;
      m_sx = 0; m_sy = 0; m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0;
      m_hres = 320; m_vres = 240; m_w = 320; m_h = 240;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_all("R1");

      // R2: stored copies reset to 0, so an all-zero mode word is dropped
      put(32'h0800_0000);
      cmp_all("R2 zero mode repeat");
      put(32'h0300_0001);
      cmp_all("R5 blank on");
      clr();
      cmp_all("R3 clear");
      put(32'h0300_0001);
      cmp_all("R2 repeat blank");
      put(32'h0300_0000);
      cmp_all("R5 blank off");
      clr();

      // R5: transfer direction field
      for (int d = 3; d >= 0; d--) begin
         put(32'h0400_0000 | d);
         cmp_all("R5 dma");
      end

      // R6: start position
      put(32'h0500_0000 | (10'd777 << 10) | 10'd5);
      cmp_all("R6 start");
      put(32'h0500_0000 | (10'd1 << 10) | 10'd1023);
      cmp_all("R6 start edge");
      clr();
      put(32'h0500_0000 | (10'd1 << 10) | 10'd1023);
      cmp_all("R2 start repeat");

      // R7: all mode words
      for (int d = 0; d < 128; d++) begin
         put(32'h0800_0000 | d);
         cmp_all("R7 mode");
      end

      // R8: width under every horizontal mode
      for (int m = 0; m < 8; m++) begin
         int spans[8] = '{-5, 0, 1, 7, 1000, 2559, 2560, 3000};
         put(32'h0800_0000 | ((m >> 1) & 3) | ((m & 1) << 6));
         for (int k = 0; k < 8; k++) begin
            int x1 = 50 + 3 * k;
            int x2 = x1 + spans[k];
            put(32'h0600_0000 | (x2 << 12) | x1);
            cmp_all("R8 width");
         end
      end

      // R9: height with doubling off and on
      for (int dh = 0; dh < 2; dh++) begin
         int spans[6] = '{-3, 0, 1, 100, 300, 1023};
         put(32'h0800_0000 | (dh << 2));
         for (int k = 0; k < 6; k++) begin
            int y1 = (k == 5) ? 0 : 40 + k;
            int y2 = y1 + spans[k];
            put(32'h0700_0000 | (y2 << 10) | y1);
            cmp_all("R9 height");
         end
      end
      put(32'h0800_0004);
      put(32'h0800_0000);
      cmp_all("R9 mode undoubles");

      // R10: field parity
      put(32'h0800_0020);
      vblank(1'b1);
      cmp_all("R10 toggle");
      vblank(1'b0);
      cmp_all("R10 hold");
      vblank(1'b1);
      vblank(1'b1);
      cmp_all("R10 toggle twice");
      put(32'h0800_0000);
      cmp_all("R10 interlace off keeps");
      vblank(1'b0);
      cmp_all("R10 cleared");
      put(32'h0800_0020);
      vblank(1'b1);
      chk("R10 parity bit", int'(status_o[31]), 1);

      // R4: opcode 0 repeats are never ignored
      put(32'h0000_0000);
      cmp_all("R4 init");
      clr();
      put(32'h0000_0000);
      cmp_all("R4 init repeat");
      clr();

      // R2: unbanked opcodes only mark dirty
      put(32'h2000_1234);
      cmp_all("R2 unbanked");
      clr();
      put(32'h2000_1234);
      cmp_all("R2 unbanked again");

      // R3: an accepted write wins over a coincident clear
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h0400_0002; dirty_clr = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; dirty_clr = 1'b0;
      model(32'h0400_0002);
      cmp_all("R3 clear vs write");

      // R11: restart of a pending width computation
      put(32'h0800_0001);
      put(32'h0600_0000);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 32'h0600_0000 | (12'd1000 << 12);
      @(negedge clk);
      chk("R11 busy", int'(geom_busy_o), 1);
      chk("R11 width held", int'(width_o), m_w);
      model(32'h0600_0000 | (12'd1000 << 12));
      wr_data = 32'h0600_0000 | (12'd2000 << 12) | 12'd7;
      @(negedge clk);
      wr_en = 1'b0;
      model(32'h0600_0000 | (12'd2000 << 12) | 12'd7);
      wait_idle();
      cmp_all("R11 restart");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule